// File: doc/BRIEF.md
# Loadable Counter with Detect-and-Reload

This block is a 4-bit synchronous up-counter. Its core has a synchronous parallel load, a count enable and a carry output. A small reload controller sits in front of the core's load port. A static mode input selects the count sequence. In binary mode the counter runs freely through all sixteen states, and the external load and enable inputs drive it directly. In the three shortened modes the controller forms the minimal AND of the state bits that are one in the terminal state. It raises the core's load, so the next clock edge writes the restart value. In these modes the core counts on every clock.

All flops share one clock, and nothing is clocked by a flop output. The carry output is the last stage of the increment chain. In binary mode it can feed the count enable of a further 4-bit stage to build wider counters. An active-low asynchronous reset clears the register. A separate synchronous preset puts it at the start state of the selected mode.

Top module: `reload_counter`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0. A high `srst_i` at a rising edge sets `count_o` to 9 when `mode_i`=3 and to 0 for any other mode. This preset takes priority over load and count.
- R2: With `mode_i`=0 (binary), a high `load_i` at a rising edge writes `load_data_i` into the count, whatever the value of `cnt_en_i`.
- R3: In binary mode, with `load_i` low and `cnt_en_i` high, each edge adds one modulo 16, so 15 is followed by 0.
- R4: In binary mode, with `load_i` and `cnt_en_i` both low, the count holds its value.
- R5: `carry_o` is high exactly when the effective count enable is high and `count_o` is 15. In binary mode the effective enable is `cnt_en_i`. In the other modes it is always high.
- R6: With `mode_i`=1 (decimal), the count steps 0,1,...,9,0 on every edge. It ignores `cnt_en_i`, `load_i` and `load_data_i`.
- R7: With `mode_i`=2 (modulo 7), the count steps 0,1,...,6,0 on every edge. It ignores `cnt_en_i`, `load_i` and `load_data_i`.
- R8: With `mode_i`=3 (offset), the count starts at 9 from the preset and steps 9,10,...,14,9 on every edge. It ignores `cnt_en_i`, `load_i` and `load_data_i`.
- R9: In modes 1, 2 and 3, `carry_o` stays low, because 15 is never reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low, clears count |
| srst_i | input | 1 | Synchronous preset to the mode's start value |
| mode_i | input | 2 | 0 binary, 1 decimal, 2 modulo 7, 3 offset 9..14; change only while `srst_i` is high |
| cnt_en_i | input | 1 | Count enable (binary mode) |
| load_i | input | 1 | Parallel load request (binary mode) |
| load_data_i | input | 4 | Parallel load value (binary mode) |
| count_o | output | 4 | Current count |
| carry_o | output | 1 | Carry out of the increment chain |

## Verification
The assertions check on every cycle the per-edge transitions: load capture, increment, hold, and the preset value. They also check the terminal-to-restart step of each shortened mode, that the decimal count never leaves 0..9, and the carry conditions. Only the bench scenarios can show that each shortened mode runs its full sequence for more than two turns, and that toggling the ignored inputs in those modes leaves the sequence unchanged. The bench also covers preset in the middle of a sequence and a loaded 15 wrapping to 0 with carry.

// File: rtl/reload_counter_pkg.sv
package reload_counter_pkg;
  localparam int unsigned CNT_W = 4;

  typedef enum logic [1:0] {
    MODE_BIN  = 2'd0,
    MODE_DEC  = 2'd1,
    MODE_MOD7 = 2'd2,
    MODE_OFS  = 2'd3
  } mode_e;

  // terminal-state masks: only the bits that are one in the terminal state
  localparam logic [CNT_W-1:0] DEC_TERM_MASK  = 4'b1001;
  localparam logic [CNT_W-1:0] MOD7_TERM_MASK = 4'b0110;
  localparam logic [CNT_W-1:0] OFS_TERM_MASK  = 4'b1110;
  localparam logic [CNT_W-1:0] OFS_START      = 4'd9;
  localparam logic [CNT_W-1:0] ZERO_START     = '0;
endpackage

// File: rtl/rc_count_core.sv
module rc_count_core #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic [W-1:0] srst_val_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         en_i,
  output logic [W-1:0] q_o,
  output logic         carry_o
);
  logic [W-1:0] q_q, q_d, q_inc;
  logic [W:0]   tgl;

  assign tgl[0] = en_i;

  // serial toggle chain: bit i flips when all lower bits are one
  for (genvar i = 0; i < W; i++) begin : g_stage
    assign tgl[i+1]  = tgl[i] & q_q[i];
    assign q_inc[i]  = q_q[i] ^ tgl[i];
  end

  always_comb begin
    if (srst_i)      q_d = srst_val_i;
    else if (load_i) q_d = load_data_i;
    else             q_d = q_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o     = q_q;
  assign carry_o = tgl[W];
endmodule

// File: rtl/rc_reload_ctrl.sv
module rc_reload_ctrl
  import reload_counter_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  mode_e        mode_i,
  input  logic [W-1:0] q_i,
  input  logic         ext_load_i,
  input  logic [W-1:0] ext_data_i,
  input  logic         ext_en_i,
  output logic         load_o,
  output logic [W-1:0] load_data_o,
  output logic         en_o,
  output logic [W-1:0] start_val_o
);
  logic [W-1:0] term_mask;
  logic         term_hit;

  always_comb begin
    unique case (mode_i)
      MODE_DEC:  term_mask = DEC_TERM_MASK;
      MODE_MOD7: term_mask = MOD7_TERM_MASK;
      MODE_OFS:  term_mask = OFS_TERM_MASK;
      default:   term_mask = '0;
    endcase
  end

  // minimal product: every masked bit must be one
  assign term_hit = &(q_i | ~term_mask);

  always_comb begin
    if (mode_i == MODE_BIN) begin
      load_o      = ext_load_i;
      load_data_o = ext_data_i;
      en_o        = ext_en_i;
    end else begin
      load_o      = term_hit;
      load_data_o = (mode_i == MODE_OFS) ? OFS_START : ZERO_START;
      en_o        = 1'b1;
    end
    start_val_o = (mode_i == MODE_OFS) ? OFS_START : ZERO_START;
  end
endmodule

// File: rtl/reload_counter.sv
module reload_counter
  import reload_counter_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic [1:0]       mode_i,
  input  logic             cnt_en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             carry_o
);
  mode_e            mode;
  logic             core_load, core_en;
  logic [CNT_W-1:0] core_data, start_val, q;

  assign mode = mode_e'(mode_i);

  rc_reload_ctrl #(.W(CNT_W)) u_ctrl (
    .mode_i      (mode),
    .q_i         (q),
    .ext_load_i  (load_i),
    .ext_data_i  (load_data_i),
    .ext_en_i    (cnt_en_i),
    .load_o      (core_load),
    .load_data_o (core_data),
    .en_o        (core_en),
    .start_val_o (start_val)
  );

  rc_count_core #(.W(CNT_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .srst_i      (srst_i),
    .srst_val_i  (start_val),
    .load_i      (core_load),
    .load_data_i (core_data),
    .en_i        (core_en),
    .q_o         (q),
    .carry_o     (carry_o)
  );

  assign count_o = q;
endmodule

// File: rtl/rc_checker.sv
module rc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       srst_i,
  input logic [1:0] mode_i,
  input logic       cnt_en_i,
  input logic       load_i,
  input logic [3:0] load_data_i,
  input logic [3:0] count_o,
  input logic       carry_o
);
  // R1
  preset_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> count_o == (($past(mode_i) == 2'd3) ? 4'd9 : 4'd0));
  // R2
  bin_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && !srst_i && load_i) |=> count_o == $past(load_data_i));
  // R3
  bin_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && !srst_i && !load_i && cnt_en_i) |=> count_o == 4'($past(count_o) + 4'd1));
  // R4
  bin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && !srst_i && !load_i && !cnt_en_i) |=> $stable(count_o));
  // R5
  carry_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (count_o == 4'hf && (cnt_en_i || mode_i != 2'd0)));
  // R6
  dec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && !srst_i && count_o == 4'd9) |=> count_o == 4'd0);
  // R6
  dec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    (mode_i == 2'd1 && !$past(srst_i)) |-> count_o <= 4'd9);
  // R7
  mod7_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && !srst_i && count_o == 4'd6) |=> count_o == 4'd0);
  // R8
  ofs_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && !srst_i && count_o == 4'd14) |=> count_o == 4'd9);
  // R9
  short_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    (mode_i != 2'd0 && !$past(srst_i)) |-> !carry_o);
endmodule

bind reload_counter rc_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .srst_i      (srst_i),
  .mode_i      (mode_i),
  .cnt_en_i    (cnt_en_i),
  .load_i      (load_i),
  .load_data_i (load_data_i),
  .count_o     (count_o),
  .carry_o     (carry_o)
);

// File: tb/reload_counter_tb.sv
`timescale 1ns/1ps
module reload_counter_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       srst_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       cnt_en_i = 1'b0;
  logic       load_i = 1'b0;
  logic [3:0] load_data_i = 4'd0;
  logic [3:0] count_o;
  logic       carry_o;

  int checks = 0;
  int fails  = 0;
  logic [3:0] exp_q = 4'd0;

  always #4 clk = ~clk; // 125 MHz

  reload_counter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .srst_i(srst_i), .mode_i(mode_i),
    .cnt_en_i(cnt_en_i), .load_i(load_i), .load_data_i(load_data_i),
    .count_o(count_o), .carry_o(carry_o)
  );

  function automatic logic [3:0] ref_next(logic [1:0] m, logic [3:0] q, logic s,
                                          logic l, logic e, logic [3:0] d);
    if (s) return (m == 2'd3) ? 4'd9 : 4'd0;
    case (m)
      2'd0:    return l ? d : (e ? 4'(q + 4'd1) : q);
      2'd1:    return (q == 4'd9)  ? 4'd0 : 4'(q + 4'd1);
      2'd2:    return (q == 4'd6)  ? 4'd0 : 4'(q + 4'd1);
      default: return (q == 4'd14) ? 4'd9 : 4'(q + 4'd1);
    endcase
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(logic [1:0] m, logic s, logic l, logic e, logic [3:0] d, string tag);
    logic exp_c;
    mode_i = m; srst_i = s; load_i = l; cnt_en_i = e; load_data_i = d;
    #1;
    exp_c = ((m == 2'd0) ? e : 1'b1) && (exp_q == 4'hf);
    check((m == 2'd0) ? "R5 carry" : "R9 carry", {3'b0, carry_o}, {3'b0, exp_c});
    @(posedge clk);
    exp_q = ref_next(m, exp_q, s, l, e, d);
    @(negedge clk);
    check(tag, count_o, exp_q);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (2) @(negedge clk);
    check("R1 async reset", count_o, 4'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // binary mode directed
    step(2'd0, 1'b0, 1'b1, 1'b0, 4'd13, "R2 load");
    step(2'd0, 1'b0, 1'b0, 1'b1, 4'd0, "R3 inc");
    step(2'd0, 1'b0, 1'b0, 1'b0, 4'd3, "R4 hold");
    step(2'd0, 1'b0, 1'b0, 1'b1, 4'd0, "R3 inc to 15");
    step(2'd0, 1'b0, 1'b0, 1'b1, 4'd0, "R3 wrap 15->0 with R5 carry");
    step(2'd0, 1'b0, 1'b1, 1'b1, 4'd15, "R2 load over count");
    step(2'd0, 1'b0, 1'b0, 1'b0, 4'd0, "R4 hold at 15 R5 no carry");
    step(2'd0, 1'b1, 1'b1, 1'b1, 4'd5, "R1 preset over load");

    // binary random
    for (int i = 0; i < 300; i++) begin
      logic s, l, e;
      s = ($urandom % 16) == 0;
      l = ($urandom % 5) == 0;
      e = ($urandom % 3) != 0;
      step(2'd0, s, l, e, 4'($urandom),
           s ? "R1 preset" : (l ? "R2 load" : (e ? "R3 inc" : "R4 hold")));
    end

    // decimal, mod 7, offset: ignored inputs toggled randomly
    for (int m = 1; m < 4; m++) begin
      string tag;
      tag = (m == 1) ? "R6 seq" : ((m == 2) ? "R7 seq" : "R8 seq");
      step(2'(m), 1'b1, 1'b0, 1'b0, 4'd0, (m == 3) ? "R8 R1 preset 9" : "R1 preset 0");
      for (int i = 0; i < 25; i++)
        step(2'(m), 1'b0, 1'($urandom), 1'($urandom), 4'($urandom), tag);
      step(2'(m), 1'b1, 1'b1, 1'b1, 4'd15, "R1 preset mid sequence");
      for (int i = 0; i < 14; i++)
        step(2'(m), 1'b0, 1'($urandom), 1'($urandom), 4'($urandom), tag);
    end

    // back to binary through preset
    step(2'd0, 1'b1, 1'b0, 1'b0, 4'd0, "R1 preset binary");
    step(2'd0, 1'b0, 1'b0, 1'b1, 4'd0, "R3 inc after mode change");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule